// File: doc/BRIEF.md
# Scanline Interrupt Counter

This block sits on the cartridge side of a tile-based video system and produces a CPU interrupt a programmable number of video lines into the frame. It has no line sync input. Instead it watches bit 12 of the pixel processor's pattern-memory address. Background patterns are normally read from the lower half of pattern memory and sprite patterns from the upper half. Sprite fetches take place during horizontal blanking, so that address bit rises about once per rendered line. Each qualified rise clocks an 8-bit down-counter. When the count expires, the counter reloads from a value the CPU wrote earlier and, if interrupts are enabled, raises a level interrupt request.

The CPU drives a small write-only interface. A 2-bit select picks one of four actions: store the reload value, request a reload, disable and acknowledge, or enable. The address bit is sampled on the same pixel clock. A rise only counts once the bit has been seen low for a minimum number of consecutive samples, so the brief toggles inside a single fetch group are ignored.

Top module: `scanline_irq_counter`

## Requirements
- R1: After reset, `irq` is 0, the counter is 0 and interrupts are disabled, so counted lines alone never raise `irq` until an enable write.
- R2: A rise of `a12` is counted only if `a12` was sampled low on at least MIN_LOW (default 3) consecutive clocks just before it. With two low samples the rise is ignored, and with exactly three it counts.
- R3: On a counted rise the counter loads the stored reload value if it currently holds 0. Otherwise it decrements by one.
- R4: When a counted rise leaves the counter at 0 with interrupts enabled, `irq` goes high two clocks after the first high sample of `a12`. For a reload value N, `irq` is raised once per N+1 counted rises.
- R5: While interrupts are disabled, the counter keeps counting but `irq` is never raised.
- R6: A write with `wr_sel`=1 (reload request) forces the counter to 0, so the next counted rise reloads it instead of decrementing.
- R7: `irq` stays high across further counted rises until a write with `wr_sel`=2. That write clears both `irq` and the interrupt enable.
- R8: A write with `wr_sel`=3 sets the interrupt enable. It does not clear a pending `irq` and does not change the counter.
- R9: A write with `wr_sel`=0 stores `wr_data` as the reload value. It takes effect only at the next reload and does not alter a count in progress.
- R10: With a reload value of 0, every counted rise leaves the counter at 0, so `irq` is raised on every counted rise while enabled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | One-clock CPU write strobe |
| wr_sel | input | 2 | Write target: 0 reload value, 1 reload request, 2 disable/acknowledge, 3 enable |
| wr_data | input | 8 | Reload value, used when `wr_sel`=0 |
| a12 | input | 1 | Pattern-memory address bit 12, sampled each clock |
| irq | output | 1 | Active-high level interrupt request |

## Verification
The assertions assume that `a12` is already synchronous to `clk`. They also assume that each CPU write is a single-clock strobe with `wr_sel` and `wr_data` stable in that clock. The bench changes every input only on the falling clock edge and pulses `wr_en` for exactly one clock. Each line it models holds `a12` low for four clocks and then high for four clocks. The one exception is a filter test that uses low runs of exactly two and three clocks, so the threshold is probed at its boundary and is never crossed by accident.

// File: rtl/scanline_irq_pkg.sv
// Shared definitions for the scanline interrupt counter.
// Assumes: the CPU write select is a 2-bit code decoded as below.
package scanline_irq_pkg;
    typedef enum logic [1:0] {
        SEL_LATCH   = 2'd0,
        SEL_RELOAD  = 2'd1,
        SEL_DISABLE = 2'd2,
        SEL_ENABLE  = 2'd3
    } reg_sel_e;
endpackage

// File: rtl/a12_edge_qual.sv
// Turns raw pattern-address bit 12 into a one-clock line tick.
// A rise counts only after MIN_LOW consecutive low samples.
// Assumes: a12 is synchronous to clk.
module a12_edge_qual #(
    parameter int MIN_LOW = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic a12,
    output logic line_tick
);
    localparam int LW = $clog2(MIN_LOW + 1);
    localparam logic [LW-1:0] LOW_SAT = LW'(MIN_LOW);

    logic [LW-1:0] low_run;

    // Track the saturating low run and flag a qualified rise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            low_run   <= '0;
            line_tick <= 1'b0;
        end else begin
            line_tick <= a12 && (low_run == LOW_SAT);
            if (a12)
                low_run <= '0;
            else if (low_run != LOW_SAT)
                low_run <= low_run + 1'b1;
        end
    end
endmodule

// File: rtl/line_downcounter.sv
// Reloadable line down-counter with a stored reload value.
// It reloads when it is ticked at zero and otherwise decrements.
// Assumes: reload_req and latch_wr are single-clock strobes.
module line_downcounter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             line_tick,
    input  logic             latch_wr,
    input  logic             reload_req,
    input  logic [CNT_W-1:0] wr_data,
    output logic [CNT_W-1:0] cnt,
    output logic             hit
);
    logic [CNT_W-1:0] latch_q;
    logic [CNT_W-1:0] cnt_nxt;

    // Next count on a tick: reload at zero, else decrement.
    always_comb begin
        cnt_nxt = (cnt == '0) ? latch_q : cnt - 1'b1;
        hit     = line_tick && !reload_req && (cnt_nxt == '0);
    end

    // Hold the reload value written by the CPU.
    always_ff @(posedge clk) begin
        if (!rst_n)
            latch_q <= '0;
        else if (latch_wr)
            latch_q <= wr_data;
    end

    // Update the count; a reload request takes priority over a tick.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (reload_req)
            cnt <= '0;
        else if (line_tick)
            cnt <= cnt_nxt;
    end
endmodule

// File: rtl/irq_flag_ctrl.sv
// Interrupt enable and level request flags.
// A clear both acknowledges and disables; a set only enables.
// Assumes: set and clear strobes are never both high.
module irq_flag_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic en_set,
    input  logic en_clr,
    input  logic hit,
    output logic en_q,
    output logic irq
);
    // Enable flag: cleared by disable, set by enable.
    always_ff @(posedge clk) begin
        if (!rst_n)
            en_q <= 1'b0;
        else if (en_clr)
            en_q <= 1'b0;
        else if (en_set)
            en_q <= 1'b1;
    end

    // Request flag: set on an enabled hit, held until acknowledged.
    always_ff @(posedge clk) begin
        if (!rst_n)
            irq <= 1'b0;
        else if (en_clr)
            irq <= 1'b0;
        else if (hit && en_q)
            irq <= 1'b1;
    end
endmodule

// File: rtl/scanline_irq_counter.sv
// Top level: decodes the CPU writes and chains the edge qualifier,
// the down-counter and the interrupt flags.
// Assumes: all inputs are synchronous to the pixel clock.
module scanline_irq_counter
    import scanline_irq_pkg::*;
#(
    parameter int CNT_W   = 8,
    parameter int MIN_LOW = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_sel,
    input  logic [CNT_W-1:0] wr_data,
    input  logic             a12,
    output logic             irq
);
    logic             line_tick;
    logic             hit;
    logic             en_flag;
    logic [CNT_W-1:0] cnt_val;
    logic             wr_latch, wr_reload, wr_disable, wr_enable;

    // Decode the write select into one strobe per action.
    always_comb begin
        wr_latch   = wr_en && (wr_sel == SEL_LATCH);
        wr_reload  = wr_en && (wr_sel == SEL_RELOAD);
        wr_disable = wr_en && (wr_sel == SEL_DISABLE);
        wr_enable  = wr_en && (wr_sel == SEL_ENABLE);
    end

    a12_edge_qual #(.MIN_LOW(MIN_LOW)) u_qual (
        .clk       (clk),
        .rst_n     (rst_n),
        .a12       (a12),
        .line_tick (line_tick)
    );

    line_downcounter #(.CNT_W(CNT_W)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .line_tick  (line_tick),
        .latch_wr   (wr_latch),
        .reload_req (wr_reload),
        .wr_data    (wr_data),
        .cnt        (cnt_val),
        .hit        (hit)
    );

    irq_flag_ctrl u_flags (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_set (wr_enable),
        .en_clr (wr_disable),
        .hit    (hit),
        .en_q   (en_flag),
        .irq    (irq)
    );
endmodule

// File: rtl/scanline_irq_checker.sv
// Property checker for scanline_irq_counter, attached by bind.
// Assumes: the same clock and synchronous reset as the design.
module scanline_irq_checker
    import scanline_irq_pkg::*;
#(
    parameter int CNT_W   = 8,
    parameter int MIN_LOW = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic [1:0]       wr_sel,
    input logic             a12,
    input logic             line_tick,
    input logic [CNT_W-1:0] cnt,
    input logic             en_flag,
    input logic             irq
);
    logic [7:0] low_seen;

    // Independent saturating count of consecutive low samples.
    always_ff @(posedge clk) begin
        if (!rst_n)
            low_seen <= '0;
        else if (a12)
            low_seen <= '0;
        else if (low_seen != 8'hFF)
            low_seen <= low_seen + 8'd1;
    end

    AST_TICK_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
        line_tick |-> ($past(a12) && (int'($past(low_seen)) >= MIN_LOW))); // R2
    AST_DECREMENT: assert property (@(posedge clk) disable iff (!rst_n)
        (line_tick && cnt != '0 && !(wr_en && wr_sel == SEL_RELOAD))
        |=> (cnt == CNT_W'($past(cnt) - 1'b1))); // R3
    AST_IRQ_ON_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> (cnt == '0)); // R4
    AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(en_flag)); // R5
    AST_RELOAD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == SEL_RELOAD) |=> (cnt == '0)); // R6
    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == SEL_DISABLE) |=> (!irq && !en_flag)); // R7
    AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !(wr_en && wr_sel == SEL_DISABLE)) |=> irq); // R7
    AST_ENABLE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == SEL_ENABLE) |=> en_flag); // R8
endmodule

bind scanline_irq_counter scanline_irq_checker #(
    .CNT_W   (CNT_W),
    .MIN_LOW (MIN_LOW)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_sel    (wr_sel),
    .a12       (a12),
    .line_tick (line_tick),
    .cnt       (cnt_val),
    .en_flag   (en_flag),
    .irq       (irq)
);

// File: tb/scanline_irq_counter_tb.sv
// Directed bench: one task per scenario, each checking its own results.
module scanline_irq_counter_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_sel = 2'd0;
    logic [7:0] wr_data = 8'd0;
    logic       a12 = 1'b0;
    logic       irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    scanline_irq_counter u_dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .a12     (a12),
        .irq     (irq)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: irq actual %0b expected %0b", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] sel, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // One line: low_n low samples, then four high samples.
    task automatic line_lo(input int low_n);
        for (int i = 0; i < low_n; i++) begin
            @(negedge clk); a12 = 1'b0;
        end
        for (int i = 0; i < 4; i++) begin
            @(negedge clk); a12 = 1'b1;
        end
    endtask

    task automatic line();
        line_lo(4);
    endtask

    task automatic arm(input logic [7:0] n);
        wr(2'd2, 8'd0);
        wr(2'd0, n);
        wr(2'd1, 8'd0);
        wr(2'd3, 8'd0);
    endtask

    task automatic t_reset();
        chk("R1 reset irq", irq, 1'b0);
        wr(2'd0, 8'd1);
        for (int i = 0; i < 4; i++) line();
        chk("R1 disabled after reset", irq, 1'b0);
    endtask

    task automatic t_period(input int n);
        arm(8'(n));
        for (int i = 0; i < n; i++) line();
        chk("R3 no irq before expiry", irq, 1'b0);
        line();
        chk("R4 irq on N+1th line", irq, 1'b1);
        wr(2'd2, 8'd0); wr(2'd3, 8'd0);
        for (int i = 0; i < n; i++) line();
        chk("R3 reload then count again", irq, 1'b0);
        line();
        chk("R4 second period", irq, 1'b1);
    endtask

    task automatic t_latch0();
        arm(8'd0);
        line();
        chk("R10 irq every line", irq, 1'b1);
        wr(2'd2, 8'd0); wr(2'd3, 8'd0);
        line();
        chk("R10 irq every line again", irq, 1'b1);
    endtask

    task automatic t_filter();
        arm(8'd1);
        line();
        line_lo(2);
        chk("R2 two low samples ignored", irq, 1'b0);
        line_lo(3);
        chk("R2 three low samples counted", irq, 1'b1);
    endtask

    task automatic t_hold();
        line(); line(); line();
        chk("R7 irq held across lines", irq, 1'b1);
        wr(2'd2, 8'd0);
        chk("R7 ack clears irq", irq, 1'b0);
        line(); line(); line();
        chk("R7 ack also disables", irq, 1'b0);
    endtask

    task automatic t_enable_only();
        arm(8'd1);
        line(); line();
        wr(2'd3, 8'd0);
        chk("R8 enable keeps pending irq", irq, 1'b1);
        wr(2'd2, 8'd0);
        wr(2'd0, 8'd2);
        wr(2'd1, 8'd0);
        line(); line(); line();
        chk("R5 no irq while disabled", irq, 1'b0);
        wr(2'd3, 8'd0);
        line(); line();
        chk("R5 counter ran while disabled", irq, 1'b0);
        line();
        chk("R5 R8 period after enable", irq, 1'b1);
    endtask

    task automatic t_reload_mid();
        arm(8'd4);
        line(); line(); line();
        wr(2'd1, 8'd0);
        for (int i = 0; i < 4; i++) line();
        chk("R6 reload request restarts count", irq, 1'b0);
        line();
        chk("R6 irq after full period", irq, 1'b1);
    endtask

    task automatic t_latch_defer();
        arm(8'd2);
        line();
        wr(2'd0, 8'd5);
        line();
        chk("R9 count in progress kept", irq, 1'b0);
        line();
        chk("R9 old value expires", irq, 1'b1);
        wr(2'd2, 8'd0); wr(2'd3, 8'd0);
        for (int i = 0; i < 5; i++) line();
        chk("R9 new value used on reload", irq, 1'b0);
        line();
        chk("R9 new period", irq, 1'b1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_period(3);
        t_period(5);
        t_latch0();
        t_filter();
        t_hold();
        t_enable_only();
        t_reload_mid();
        t_latch_defer();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog: run did not complete");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule